// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives a single-wire open-drain bus on which one conductor carries both data and timing. It produces bus reset pulses and checks for a presence reply. It also runs data slots that each write one bit and read one bit back. All timing comes from a microsecond tick that a programmable clock divider generates. Every duration is an input given as a count of those ticks, so the same logic works for standard or overdrive timing.

Software queues outgoing data into an 8-bit, 16-entry transmit FIFO and collects replies from a receive FIFO of the same size. In byte mode one entry becomes eight slots. In bit mode one entry becomes a single slot. A read slot is a write-1 slot whose sampled level is the bit the device returns. In bypass mode the FIFOs are left alone and a software input pulls the line low directly. The block only ever pulls the line low. The pad applies `owDriveLow` as an open-drain pull-down and feeds the wire level back on `owLineIn`.

Top module: `onewire_master`

## Requirements
- R1: After reset, `owDriveLow` is 0, `busy` is 0, `noPresence` is 0, both FIFOs report empty and neither reports full.
- R2: Each FIFO holds 16 entries of 8 bits. `txFull` rises after 16 pushes with nothing drained, a push into a full transmit FIFO is dropped, and receive entries come out in the order they were produced.
- R3: The microsecond tick occurs once every `divFactor`+1 clock cycles. Every bus duration listed below is that many clock cycles per microsecond.
- R4: A `cmdReset` pulse accepted while idle pulls the line low for `tResetLow` µs and then releases it for a further `tResetLow` µs. `busy` stays high for the whole 2×`tResetLow` µs.
- R5: The line is sampled `tPresSample` µs after the reset pulse is released. `noPresence` becomes 1 if the line is high there and 0 if it is low, and it keeps that value while idle.
- R6: Every slot lasts `tSlot` µs and starts by pulling the line low. The line stays low for `tWr1Low` µs when the bit sent is 1 and for `tWr0Low` µs when it is 0, and the line is sampled at `tRdSample` µs. Consecutive slots of one byte start exactly `tSlot` µs apart.
- R7: With `modeSel` = 1 (byte mode), each transmit entry gives eight slots sent least significant bit first. The eight sampled bits are packed least significant bit first into one receive entry.
- R8: With `modeSel` = 0 (bit mode), each transmit entry gives one slot that sends bit 0 of the entry. The receive entry holds the sampled bit in bit 0, and bits 7..1 are zero.
- R9: No slot starts while the transmit FIFO is empty or the receive FIFO is full. Transfers resume on their own once data or space appears.
- R10: While `modeSel[1]` = 1 (bypass), `owDriveLow` equals `bypassLow`, the transmit FIFO is not drained and `cmdReset` is ignored.
- R11: When the block is idle and not in bypass, `owDriveLow` is 0 (1 means pull the line low, 0 means release it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| divFactor | input | 8 | Tick divider: a tick every divFactor+1 clocks |
| modeSel | input | 2 | 0 bit mode, 1 byte mode, 2 or 3 bypass |
| tResetLow | input | 10 | Reset low time and release time, µs |
| tPresSample | input | 10 | Presence sample point after release, µs |
| tWr1Low | input | 10 | Low time of a 1 slot, µs |
| tWr0Low | input | 10 | Low time of a 0 slot, µs |
| tRdSample | input | 10 | Sample point within a slot, µs |
| tSlot | input | 10 | Slot length, µs |
| cmdReset | input | 1 | Request a reset/presence sequence |
| bypassLow | input | 1 | Direct line pull-down in bypass |
| txPush | input | 1 | Write txData into the transmit FIFO |
| txData | input | 8 | Transmit entry |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxPop | input | 1 | Remove the head receive entry |
| rxData | output | 8 | Head receive entry |
| rxFull | output | 1 | Receive FIFO full |
| rxEmpty | output | 1 | Receive FIFO empty |
| busy | output | 1 | A reset sequence or slot is in progress |
| noPresence | output | 1 | Last reset got no presence reply |
| owDriveLow | output | 1 | 1 pulls the bus low |
| owLineIn | input | 1 | Bus level |

## Verification
A slot starts on the second clock edge after a transmit push: one edge to store the entry and one for the controller to leave idle. From that edge every line event falls a whole number of ticks later. Pulse widths are therefore checked as exact cycle counts (µs × (divFactor+1)), and slot starts as exact spacings. The reset sequence is checked by counting falling clock edges from the command until `busy` drops, which must equal 2×`tResetLow`×(divFactor+1)+1. Sampled bits pass through a two-stage input synchronizer, so the bench's device model holds its reply from the first cycle after the master's edge until late in the slot. Every sample point then falls inside a stable window, and received bytes are compared with the sent bit ANDed with the modelled reply.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam logic [1:0] MODE_BIT  = 2'd0;
  localparam logic [1:0] MODE_BYTE = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RLOW,
    ST_RWAIT,
    ST_SLOT
  } owState_t;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic clrTimer;   // restart divider and microsecond counter
    logic loadTx;     // take a fresh transmit entry
    logic nextBit;    // advance to next bit of the byte
    logic sampleBit;  // shift the synchronized line into the shifter
    logic rstLow;     // reset pulse in progress
    logic slotOn;     // data slot in progress
  } owStrobe_t;
endpackage

// File: rtl/owm_fifo.sv
module owm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign full   = (count == (AW+1)'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int TIME_W      = 10,
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  owStrobe_t         strb,
  input  logic [DIV_W-1:0]  divFactor,
  input  logic [TIME_W-1:0] tWr1Low,
  input  logic [TIME_W-1:0] tWr0Low,
  input  logic [DATA_W-1:0] txData,
  input  logic              byteMode,
  input  logic              bypass,
  input  logic              bypassLow,
  input  logic              lineIn,
  output logic              tick,
  output logic [TIME_W-1:0] usCnt,
  output logic              lineSync,
  output logic [DATA_W-1:0] rxByte,
  output logic              driveLow
);
  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] shReg;
  logic              curBit;
  logic [TIME_W-1:0] lowTime;

  assign tick = (divCnt == divFactor);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (strb.clrTimer) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (tick) begin
      divCnt <= '0;
      usCnt  <= usCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // input synchronizer, idle value is the released (high) line
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= lineIn;
      end
      assign lineSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
      assign lineSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      curBit <= 1'b1;
    end else if (strb.loadTx) begin
      shReg  <= txData;
      curBit <= txData[0];
    end else if (strb.sampleBit) begin
      shReg  <= {lineSync, shReg[DATA_W-1:1]};
    end else if (strb.nextBit) begin
      curBit <= shReg[0];
    end
  end

  assign rxByte   = byteMode ? shReg : {{(DATA_W-1){1'b0}}, shReg[DATA_W-1]};
  assign lowTime  = curBit ? tWr1Low : tWr0Low;
  assign driveLow = bypass ? bypassLow
                           : (strb.rstLow || (strb.slotOn && (usCnt < lowTime)));
endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
#(
  parameter int TIME_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              cmdReset,
  input  logic [TIME_W-1:0] tResetLow,
  input  logic [TIME_W-1:0] tPresSample,
  input  logic [TIME_W-1:0] tRdSample,
  input  logic [TIME_W-1:0] tSlot,
  input  logic              tick,
  input  logic [TIME_W-1:0] usCnt,
  input  logic              lineSync,
  input  logic              txEmpty,
  input  logic              rxFull,
  output owStrobe_t         strb,
  output logic              txPop,
  output logic              rxPush,
  output logic              byteMode,
  output logic              busy,
  output logic              noPresence
);
  localparam int BC_W = $clog2(DATA_W);

  owState_t          state, nxt;
  logic [BC_W-1:0]   bitsLeft;
  logic              bypass, presHit;
  logic [TIME_W-1:0] rstEnd, presAt, sampAt, slotEnd;

  assign bypass  = modeSel[1];
  assign rstEnd  = tResetLow - 1'b1;
  assign presAt  = tPresSample - 1'b1;
  assign sampAt  = tRdSample - 1'b1;
  assign slotEnd = tSlot - 1'b1;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb        = '0;
    strb.rstLow = (state == ST_RLOW);
    strb.slotOn = (state == ST_SLOT);
    txPop       = 1'b0;
    rxPush      = 1'b0;
    presHit     = 1'b0;
    nxt         = state;
    case (state)
      ST_IDLE: begin
        if (!bypass) begin
          if (cmdReset) begin
            strb.clrTimer = 1'b1;
            nxt           = ST_RLOW;
          end else if (!txEmpty && !rxFull) begin
            txPop         = 1'b1;
            strb.loadTx   = 1'b1;
            strb.clrTimer = 1'b1;
            nxt           = ST_SLOT;
          end
        end
      end
      ST_RLOW: begin
        if (tick && usCnt == rstEnd) begin
          strb.clrTimer = 1'b1;
          nxt           = ST_RWAIT;
        end
      end
      ST_RWAIT: begin
        if (tick && usCnt == presAt) presHit = 1'b1;
        if (tick && usCnt == rstEnd) nxt = ST_IDLE;
      end
      ST_SLOT: begin
        if (tick && usCnt == sampAt) strb.sampleBit = 1'b1;
        if (tick && usCnt == slotEnd) begin
          if (bitsLeft == '0) begin
            rxPush = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            strb.nextBit  = 1'b1;
            strb.clrTimer = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitsLeft   <= '0;
      byteMode   <= 1'b0;
      noPresence <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.loadTx) begin
        byteMode <= (modeSel == MODE_BYTE);
        bitsLeft <= (modeSel == MODE_BYTE) ? BC_W'(DATA_W-1) : '0;
      end else if (strb.nextBit) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
      if (presHit) noPresence <= lineSync;
    end
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int TIME_W      = 10,
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divFactor,
  input  logic [1:0]        modeSel,
  input  logic [TIME_W-1:0] tResetLow,
  input  logic [TIME_W-1:0] tPresSample,
  input  logic [TIME_W-1:0] tWr1Low,
  input  logic [TIME_W-1:0] tWr0Low,
  input  logic [TIME_W-1:0] tRdSample,
  input  logic [TIME_W-1:0] tSlot,
  input  logic              cmdReset,
  input  logic              bypassLow,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txData,
  output logic              txFull,
  output logic              txEmpty,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              busy,
  output logic              noPresence,
  output logic              owDriveLow,
  input  logic              owLineIn
);
  owStrobe_t         strb;
  logic              tick, lineSync, byteMode, txPopInt, rxPushInt;
  logic [TIME_W-1:0] usCnt;
  logic [DATA_W-1:0] txHead, rxByte;

  owm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .wrData(txData),
    .pop(txPopInt), .rdData(txHead), .full(txFull), .empty(txEmpty)
  );

  owm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPushInt), .wrData(rxByte),
    .pop(rxPop), .rdData(rxData), .full(rxFull), .empty(rxEmpty)
  );

  owm_control #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .cmdReset(cmdReset),
    .tResetLow(tResetLow), .tPresSample(tPresSample),
    .tRdSample(tRdSample), .tSlot(tSlot),
    .tick(tick), .usCnt(usCnt), .lineSync(lineSync),
    .txEmpty(txEmpty), .rxFull(rxFull),
    .strb(strb), .txPop(txPopInt), .rxPush(rxPushInt),
    .byteMode(byteMode), .busy(busy), .noPresence(noPresence)
  );

  owm_datapath #(.TIME_W(TIME_W), .DIV_W(DIV_W), .DATA_W(DATA_W),
                 .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divFactor(divFactor),
    .tWr1Low(tWr1Low), .tWr0Low(tWr0Low), .txData(txHead),
    .byteMode(byteMode), .bypass(modeSel[1]), .bypassLow(bypassLow),
    .lineIn(owLineIn), .tick(tick), .usCnt(usCnt), .lineSync(lineSync),
    .rxByte(rxByte), .driveLow(owDriveLow)
  );
endmodule

// File: rtl/onewire_master_chk.sv
module onewire_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       driveLow,
  input logic [1:0] modeSel,
  input logic       noPresence,
  input logic       txPop,
  input logic       txEmpty,
  input logic       rxPush,
  input logic       rxFull
);
  // R11: idle outside bypass means the line is released
  a_r11_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !modeSel[1]) |-> !driveLow);

  // R9: never take an entry from an empty transmit queue
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

  // R9: never deliver into a full receive queue
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  // R5: presence flag holds while nothing is running
  a_r5_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |=> $stable(noPresence));

  // R7: received entries only appear at the end of an active transfer
  a_r7_push_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> busy);

  // R10: bypass never starts a transfer from idle
  a_r10_bypass_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1] && !busy) |=> !busy);
endmodule

bind onewire_master onewire_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .driveLow(owDriveLow),
  .modeSel(modeSel), .noPresence(noPresence), .txPop(txPopInt),
  .txEmpty(txEmpty), .rxPush(rxPushInt), .rxFull(rxFull)
);

// File: tb/tb_onewire_master.sv
module tb_onewire_master;
  localparam int RST_US = 12, PRES_US = 5, W1_US = 1, W0_US = 6, RD_US = 4, SLOT_US = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divFactor = '0;
  logic [1:0] modeSel = 2'd2;
  logic       cmdReset = 1'b0, bypassLow = 1'b0, txPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txData = '0;
  logic       txFull, txEmpty, rxFull, rxEmpty, busy, noPresence, owDriveLow;
  logic [7:0] rxData;
  logic       slaveLow = 1'b0;
  logic       owLineIn;

  int nChecks = 0, nErr = 0;
  int curP = 1;
  bit slavePresent = 1'b1;

  always #10 clk = ~clk;

  assign owLineIn = !(owDriveLow || slaveLow);

  onewire_master dut (
    .clk(clk), .rstN(rstN), .divFactor(divFactor), .modeSel(modeSel),
    .tResetLow(10'(RST_US)), .tPresSample(10'(PRES_US)), .tWr1Low(10'(W1_US)),
    .tWr0Low(10'(W0_US)), .tRdSample(10'(RD_US)), .tSlot(10'(SLOT_US)),
    .cmdReset(cmdReset), .bypassLow(bypassLow), .txPush(txPush), .txData(txData),
    .txFull(txFull), .txEmpty(txEmpty), .rxPop(rxPop), .rxData(rxData),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .busy(busy), .noPresence(noPresence),
    .owDriveLow(owDriveLow), .owLineIn(owLineIn)
  );

  // device model and pulse recorder
  int pw [512];
  int ps [512];
  int pcnt = 0, rcnt = 0, wcur = 0, hold = 0, cyc = 0;
  logic dlPrev = 1'b0;

  function automatic bit respFn(int n);
    return 1'(((n * 7) + (n >> 2)) >> 1);
  endfunction

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    dlPrev <= owDriveLow;
    if (owDriveLow && !dlPrev) begin
      ps[rcnt & 511] <= cyc;
      rcnt     <= rcnt + 1;
      wcur     <= 1;
      slaveLow <= !respFn(rcnt);
      hold     <= SLOT_US * curP - 3;
    end else begin
      if (owDriveLow) wcur <= wcur + 1;
      if (!owDriveLow && dlPrev) begin
        pw[pcnt & 511] <= wcur;
        pcnt <= pcnt + 1;
        if (wcur >= RST_US * curP && slavePresent) begin
          slaveLow <= 1'b1;
          hold     <= PRES_US * curP + 2;
        end else if (hold > 0) hold <= hold - 1;
        else slaveLow <= 1'b0;
      end else if (hold > 0) hold <= hold - 1;
      else slaveLow <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    repeat (3) @(negedge clk);
    while ((busy || (!txEmpty && !rxFull && !modeSel[1])) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pushTx(input logic [7:0] v);
    txData = v;
    txPush = 1'b1;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popRx(output logic [7:0] v);
    v = rxData;
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic doReset(input bit present);
    int base, cnt;
    slavePresent = present;
    base = pcnt;
    cmdReset = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cmdReset = 1'b0;
      cnt++;
    end while (busy && cnt < 5000);
    check(cnt == 2 * RST_US * curP + 1, "R4 sequence length", cnt, 2 * RST_US * curP + 1);
    @(negedge clk);
    check(pcnt == base + 1, "R4 pulse count", pcnt - base, 1);
    check(pw[base & 511] == RST_US * curP, "R4/R3 reset low width", pw[base & 511], RST_US * curP);
    check(noPresence == !present, "R5 presence flag", noPresence, !present);
  endtask

  task automatic runByte(input logic [7:0] tx);
    int base;
    logic [7:0] got, exp;
    base = pcnt;
    pushTx(tx);
    waitIdle();
    @(negedge clk);
    check(pcnt == base + 8, "R7 slot count", pcnt - base, 8);
    exp = '0;
    for (int i = 0; i < 8; i++) begin
      int ew;
      ew = (tx[i] ? W1_US : W0_US) * curP;
      check(pw[(base + i) & 511] == ew, "R6/R7 low width lsb first", pw[(base + i) & 511], ew);
      if (i > 0)
        check(ps[(base + i) & 511] - ps[(base + i - 1) & 511] == SLOT_US * curP,
              "R6 slot spacing", ps[(base + i) & 511] - ps[(base + i - 1) & 511], SLOT_US * curP);
      exp[i] = tx[i] & respFn(base + i);
    end
    check(!rxEmpty, "R7 byte delivered", rxEmpty, 0);
    popRx(got);
    check(got == exp, "R7 received byte", got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!owDriveLow && !busy && !noPresence, "R1 idle outputs", {owDriveLow, busy, noPresence}, 0);
    check(txEmpty && rxEmpty && !txFull && !rxFull, "R1 fifo flags",
          {txEmpty, rxEmpty, txFull, rxFull}, 4'b1100);

    // divider sweep: reset sequences and byte transfers
    for (int p = 1; p <= 3; p++) begin
      divFactor = 8'(p - 1);
      curP = p;
      modeSel = 2'd1;
      @(negedge clk);
      doReset(1'b1);
      doReset(1'b0);
      doReset(1'b1);
      runByte(8'h00);
      runByte(8'hFF);
      runByte(8'hA5);
      runByte(8'h3C);
      runByte(8'(p * 37 + 1));
    end

    // bit mode, fifo depth and stalls
    divFactor = 8'd0;
    curP = 1;
    modeSel = 2'd2;
    @(negedge clk);
    for (int i = 0; i < 16; i++) pushTx(8'(i * 3 + 1));
    check(txFull, "R2 tx full after 16", txFull, 1);
    pushTx(8'h55);  // dropped
    base = pcnt;
    repeat (20) @(negedge clk);
    check(pcnt == base && !txEmpty, "R10 bypass leaves fifo", pcnt - base, 0);
    modeSel = 2'd0;
    waitIdle();
    @(negedge clk);
    check(pcnt == base + 16, "R2 dropped push / R8 one slot per entry", pcnt - base, 16);
    check(rxFull && txEmpty, "R2 rx full after 16", {rxFull, txEmpty}, 2'b11);
    pushTx(8'h01);
    repeat (60) @(negedge clk);
    check(pcnt == base + 16 && !busy, "R9 stall on rx full", pcnt - base, 16);
    check(!txEmpty, "R9 entry waits", txEmpty, 0);
    for (int i = 0; i < 17; i++) begin
      logic [7:0] txv, ev;
      int ew;
      if (i == 1) waitIdle();
      txv = (i == 16) ? 8'h01 : 8'(i * 3 + 1);
      if (i == 16) begin
        check(pcnt == base + 17, "R9 resumes after pop", pcnt - base, 17);
        check(txEmpty, "R9 drained", txEmpty, 1);
      end
      ew = (txv[0] ? W1_US : W0_US);
      check(pw[(base + i) & 511] == ew, "R8 bit0 width", pw[(base + i) & 511], ew);
      ev = {7'b0, txv[0] & respFn(base + i)};
      popRx(v);
      check(v == ev, "R8/R2 bit entry in order", v, ev);
    end
    check(rxEmpty, "R2 rx empty after drain", rxEmpty, 1);

    // stall on empty tx
    base = pcnt;
    repeat (40) @(negedge clk);
    check(pcnt == base && !busy, "R9 idle with empty tx", pcnt - base, 0);

    // bypass
    modeSel = 2'd2;
    bypassLow = 1'b1;
    @(negedge clk);
    check(owDriveLow == 1'b1, "R10 bypass low", owDriveLow, 1);
    bypassLow = 1'b0;
    @(negedge clk);
    check(owDriveLow == 1'b0, "R10 bypass release", owDriveLow, 0);
    base = pcnt;
    cmdReset = 1'b1;
    @(negedge clk);
    cmdReset = 1'b0;
    repeat (5) @(negedge clk);
    check(!busy && pcnt == base && !owDriveLow, "R10 reset ignored in bypass", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule